// File: doc/BRIEF.md
# Thread Context Allocator with Register-Set First Policy

This block hands out execution contexts to newly created threads in a non-blocking multithreaded processor. It manages two independent pools: a small pool of hardware register sets and a larger pool of frame-memory slots. Each create request carries the start address of the new thread's code and its synchronization count. The allocator tries the register-set pool first. A thread placed in a register set gets its inputs written straight into its registers, so it needs no pre-load phase. Only when every register set is taken does the allocator grant a frame slot, and it marks that thread as needing a pre-load later. If both pools are full the request is refused and no state changes.

Each pool keeps a free bitmap, and the lowest-numbered free entry is granted. The response comes out one cycle after the request. Release commands give an entry back to its pool. A release that names an entry that is already free, or an index beyond the pool, is ignored and raises a one-cycle error pulse. When a release and a create arrive in the same cycle, the release takes effect first, so the freed entry can be granted at once. The start address and synchronization count of every granted context are held in a per-pool record table. A combinational read port exposes that table.

The response controller is a four-state machine. The state holds the kind of response for the current cycle. RSP_IDLE means no response. RSP_REGSET means a register set was granted. RSP_FRAME means a frame slot was granted. RSP_REFUSE means both pools were full. On every clock the next state is chosen from the request and the pool status: no create leads to RSP_IDLE; a create with a free register set leads to RSP_REGSET; a create with only a free frame leads to RSP_FRAME; a create with neither leads to RSP_REFUSE. Any state can move to any other state.

Top module: `thread_ctx_alloc`

## Requirements
- R1: After reset every register set and every frame slot is free, `rsp_valid` and `rel_err` are 0, and the first create is granted register set 0.
- R2: A create that finds a free register set is answered on the next cycle with `rsp_valid`=1, `rsp_ok`=1, `rsp_is_frame`=0 (0 means register set), `rsp_needs_preload`=0, and `rsp_idx` equal to the lowest-numbered free register set.
- R3: A create that finds no free register set but a free frame slot is answered on the next cycle with `rsp_ok`=1, `rsp_is_frame`=1, `rsp_needs_preload`=1, and `rsp_idx` equal to the lowest-numbered free frame slot.
- R4: A create that finds both pools full is answered on the next cycle with `rsp_valid`=1 and `rsp_ok`=0, and no entry of either pool changes state.
- R5: From the cycle after a grant, the read port (`rd_is_frame`, `rd_idx`) returns the start address and synchronization count of the create that was granted that entry.
- R6: A release of a busy entry (`rel_is_frame` selects the pool, 1 means frame) makes that entry free again, and a later create can be granted it under the lowest-index rule.
- R7: A release of an entry that is already free, or of an index that is not less than the pool size, changes no state. It sets `rel_err` to 1 for exactly the next cycle. A valid release leaves `rel_err` at 0.
- R8: When a release and a create arrive in the same cycle, the release is applied first, so the entry it frees can be granted to that create.
- R9: `rsp_valid` is 1 in exactly the cycles that follow a cycle with `create_valid`=1, and each create receives exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| create_valid | input | 1 | Thread creation request |
| create_addr | input | ADDR_W | Code start address of the new thread |
| create_sync | input | SYNC_W | Synchronization count of the new thread |
| rel_valid | input | 1 | Release command |
| rel_is_frame | input | 1 | Pool of the release: 0 register set, 1 frame slot |
| rel_idx | input | IDX_W | Index of the entry to release |
| rsp_valid | output | 1 | Response to the previous cycle's create |
| rsp_ok | output | 1 | 1 means granted, 0 means refused |
| rsp_is_frame | output | 1 | Kind granted: 0 register set, 1 frame slot |
| rsp_idx | output | IDX_W | Granted register-set number or frame pointer |
| rsp_needs_preload | output | 1 | The granted context needs a pre-load phase |
| rel_err | output | 1 | One-cycle pulse for an ignored release |
| rd_is_frame | input | 1 | Record read pool select |
| rd_idx | input | IDX_W | Record read index |
| rd_addr | output | ADDR_W | Stored start address |
| rd_sync | output | SYNC_W | Stored synchronization count |

## Verification
On every cycle, the assertions check several things: each create gets exactly one response one cycle later; a full-pool create is refused; the fallback to a frame happens only when no register set is free; the granted entry is the lowest free one and is marked busy afterwards; and an ignored release leaves the bitmap unchanged while raising the error pulse. Some behaviours need a sequence of operations, and only the bench's scenarios can show them. These are the contents of the record table, whether a released entry comes back in lowest-index order, whether a refused request really leaves nothing behind, and whether a release in the same cycle as a create hands that exact entry to the create.

// File: rtl/ctx_alloc_pkg.sv
package ctx_alloc_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_REGSET = 2'd1,
        RSP_FRAME  = 2'd2,
        RSP_REFUSE = 2'd3
    } rsp_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ctx_lowest_free.sv
module ctx_lowest_free #(
    parameter int N  = 4,
    parameter int IW = 3
) (
    input  logic [N-1:0]  free_map,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  hot
);

    always_comb begin
        idx = '0;
        hot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_map[i]) begin
                idx    = IW'(i);
                hot    = '0;
                hot[i] = 1'b1;
            end
        end
        found = |free_map;
    end

endmodule

// File: rtl/ctx_free_pool.sv
module ctx_free_pool #(
    parameter int N  = 4,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rel_valid,
    input  logic [IW-1:0] rel_idx,
    input  logic          take,
    output logic          avail,
    output logic [IW-1:0] pick_idx,
    output logic          rel_bad
);

    logic [N-1:0] free_q;
    logic [N-1:0] free_eff;
    logic [N-1:0] rel_hot;
    logic [N-1:0] rel_ok_hot;
    logic [N-1:0] pick_hot;
    logic [N-1:0] free_d;

    // decode the release index entry by entry; out-of-range hits nothing
    for (genvar g = 0; g < N; g++) begin : g_rel_dec
        assign rel_hot[g] = rel_valid && (rel_idx == IW'(g));
    end

    assign rel_ok_hot = rel_hot & ~free_q;
    assign rel_bad    = rel_valid && (rel_ok_hot == '0);
    // release lands before the pick in the same cycle
    assign free_eff   = free_q | rel_ok_hot;

    ctx_lowest_free #(.N(N), .IW(IW)) u_pick (
        .free_map (free_eff),
        .found    (avail),
        .idx      (pick_idx),
        .hot      (pick_hot)
    );

    always_comb begin
        free_d = free_eff;
        if (take) free_d = free_eff & ~pick_hot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= free_d;
    end

    // R2
    lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avail |-> ((free_eff & (pick_hot - N'(1))) == '0));

    // R6
    taken_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((free_q & $past(pick_hot)) == '0));

    // R7
    bad_release_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_bad && !take) |=> $stable(free_q));

endmodule

// File: rtl/ctx_record_file.sv
module ctx_record_file #(
    parameter int N      = 4,
    parameter int IW     = 3,
    parameter int ADDR_W = 16,
    parameter int SYNC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SYNC_W-1:0] wr_sync,
    input  logic [IW-1:0]     rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [SYNC_W-1:0] rd_sync
);

    logic [ADDR_W-1:0] addr_q [N];
    logic [SYNC_W-1:0] sync_q [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[g] <= '0;
                sync_q[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                addr_q[g] <= wr_addr;
                sync_q[g] <= wr_sync;
            end
        end
    end

    always_comb begin
        rd_addr = '0;
        rd_sync = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_addr = addr_q[i];
                rd_sync = sync_q[i];
            end
        end
    end

endmodule

// File: rtl/thread_ctx_alloc.sv
module thread_ctx_alloc
    import ctx_alloc_pkg::*;
#(
    parameter int NUM_REGSETS = 4,
    parameter int NUM_FRAMES  = 6,
    parameter int ADDR_W      = 16,
    parameter int SYNC_W      = 6,
    localparam int MAX_N      = max_of(NUM_REGSETS, NUM_FRAMES),
    localparam int IDX_W      = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              create_valid,
    input  logic [ADDR_W-1:0] create_addr,
    input  logic [SYNC_W-1:0] create_sync,
    input  logic              rel_valid,
    input  logic              rel_is_frame,
    input  logic [IDX_W-1:0]  rel_idx,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_is_frame,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic              rsp_needs_preload,
    output logic              rel_err,
    input  logic              rd_is_frame,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [SYNC_W-1:0] rd_sync
);

    rsp_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             rel_err_q;

    logic             reg_avail, frm_avail;
    logic [IDX_W-1:0] reg_pick, frm_pick;
    logic             reg_bad, frm_bad;
    logic             take_reg, take_frm;
    logic [ADDR_W-1:0] reg_rd_addr, frm_rd_addr;
    logic [SYNC_W-1:0] reg_rd_sync, frm_rd_sync;

    assign take_reg = create_valid && reg_avail;
    assign take_frm = create_valid && !reg_avail && frm_avail;

    ctx_free_pool #(.N(NUM_REGSETS), .IW(IDX_W)) u_reg_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .rel_valid (rel_valid && !rel_is_frame),
        .rel_idx   (rel_idx),
        .take      (take_reg),
        .avail     (reg_avail),
        .pick_idx  (reg_pick),
        .rel_bad   (reg_bad)
    );

    ctx_free_pool #(.N(NUM_FRAMES), .IW(IDX_W)) u_frm_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .rel_valid (rel_valid && rel_is_frame),
        .rel_idx   (rel_idx),
        .take      (take_frm),
        .avail     (frm_avail),
        .pick_idx  (frm_pick),
        .rel_bad   (frm_bad)
    );

    ctx_record_file #(.N(NUM_REGSETS), .IW(IDX_W), .ADDR_W(ADDR_W), .SYNC_W(SYNC_W)) u_reg_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take_reg),
        .wr_idx  (reg_pick),
        .wr_addr (create_addr),
        .wr_sync (create_sync),
        .rd_idx  (rd_idx),
        .rd_addr (reg_rd_addr),
        .rd_sync (reg_rd_sync)
    );

    ctx_record_file #(.N(NUM_FRAMES), .IW(IDX_W), .ADDR_W(ADDR_W), .SYNC_W(SYNC_W)) u_frm_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take_frm),
        .wr_idx  (frm_pick),
        .wr_addr (create_addr),
        .wr_sync (create_sync),
        .rd_idx  (rd_idx),
        .rd_addr (frm_rd_addr),
        .rd_sync (frm_rd_sync)
    );

    assign rd_addr = rd_is_frame ? frm_rd_addr : reg_rd_addr;
    assign rd_sync = rd_is_frame ? frm_rd_sync : reg_rd_sync;

    // next-state selection
    always_comb begin
        state_d = RSP_IDLE;
        idx_d   = '0;
        if (create_valid) begin
            if (reg_avail) begin
                state_d = RSP_REGSET;
                idx_d   = reg_pick;
            end else if (frm_avail) begin
                state_d = RSP_FRAME;
                idx_d   = frm_pick;
            end else begin
                state_d = RSP_REFUSE;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RSP_IDLE;
            idx_q     <= '0;
            rel_err_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            idx_q     <= idx_d;
            rel_err_q <= reg_bad || frm_bad;
        end
    end

    // outputs
    always_comb begin
        rsp_valid         = 1'b0;
        rsp_ok            = 1'b0;
        rsp_is_frame      = 1'b0;
        rsp_needs_preload = 1'b0;
        rsp_idx           = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_REGSET: begin
                rsp_valid = 1'b1;
                rsp_ok    = 1'b1;
                rsp_idx   = idx_q;
            end
            RSP_FRAME: begin
                rsp_valid         = 1'b1;
                rsp_ok            = 1'b1;
                rsp_is_frame      = 1'b1;
                rsp_needs_preload = 1'b1;
                rsp_idx           = idx_q;
            end
            RSP_REFUSE: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign rel_err = rel_err_q;

    // R9
    create_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        create_valid |=> rsp_valid);

    // R9
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !create_valid |=> !rsp_valid);

    // R4
    refuse_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (create_valid && !reg_avail && !frm_avail) |=> (rsp_valid && !rsp_ok));

    // R3
    frame_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (create_valid && !reg_avail && frm_avail) |=> (rsp_ok && rsp_is_frame && rsp_needs_preload));

    // R2
    regset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (create_valid && reg_avail) |=> (rsp_ok && !rsp_is_frame && !rsp_needs_preload));

    // R7
    bad_release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && (reg_bad || frm_bad)) |=> rel_err);

endmodule

// File: tb/tb_thread_ctx_alloc.sv
module tb_thread_ctx_alloc;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 4;
    localparam int NFRM = 6;
    localparam int AW = 16;
    localparam int SW = 6;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic create_valid = 1'b0;
    logic [AW-1:0] create_addr = '0;
    logic [SW-1:0] create_sync = '0;
    logic rel_valid = 1'b0;
    logic rel_is_frame = 1'b0;
    logic [IW-1:0] rel_idx = '0;
    logic rsp_valid, rsp_ok, rsp_is_frame, rsp_needs_preload, rel_err;
    logic [IW-1:0] rsp_idx;
    logic rd_is_frame = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [AW-1:0] rd_addr;
    logic [SW-1:0] rd_sync;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    thread_ctx_alloc #(.NUM_REGSETS(NREG), .NUM_FRAMES(NFRM), .ADDR_W(AW), .SYNC_W(SW)) dut (
        .clk(clk), .rst_n(rst_n),
        .create_valid(create_valid), .create_addr(create_addr), .create_sync(create_sync),
        .rel_valid(rel_valid), .rel_is_frame(rel_is_frame), .rel_idx(rel_idx),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_is_frame(rsp_is_frame),
        .rsp_idx(rsp_idx), .rsp_needs_preload(rsp_needs_preload), .rel_err(rel_err),
        .rd_is_frame(rd_is_frame), .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_sync(rd_sync)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // create, optionally with a release in the same cycle; checks response and record
    task automatic create_op(input int addr, input int sync, input bit exp_ok,
                             input bit exp_frame, input int exp_idx, input string tag,
                             input bit with_rel = 0, input bit rfrm = 0, input int ridx = 0);
        create_valid = 1'b1;
        create_addr  = AW'(addr);
        create_sync  = SW'(sync);
        rel_valid    = with_rel;
        rel_is_frame = rfrm;
        rel_idx      = IW'(ridx);
        @(negedge clk);
        create_valid = 1'b0;
        rel_valid    = 1'b0;
        chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, int'(rsp_valid), 1);
        chk(rsp_ok == exp_ok, {tag, " rsp_ok"}, int'(rsp_ok), int'(exp_ok));
        if (exp_ok) begin
            chk(rsp_is_frame == exp_frame, {tag, " kind"}, int'(rsp_is_frame), int'(exp_frame));
            chk(int'(rsp_idx) == exp_idx, {tag, " idx"}, int'(rsp_idx), exp_idx);
            chk(rsp_needs_preload == exp_frame, {tag, " preload"}, int'(rsp_needs_preload), int'(exp_frame));
            rd_is_frame = exp_frame;
            rd_idx      = IW'(exp_idx);
            #1;
            chk(int'(rd_addr) == addr, {tag, " R5 record addr"}, int'(rd_addr), addr);
            chk(int'(rd_sync) == sync, {tag, " R5 record sync"}, int'(rd_sync), sync);
        end
        if (with_rel)
            chk(rel_err == 1'b0, {tag, " rel_err"}, int'(rel_err), 0);
    endtask

    task automatic release_op(input bit frm, input int idx, input bit exp_err, input string tag);
        rel_valid    = 1'b1;
        rel_is_frame = frm;
        rel_idx      = IW'(idx);
        @(negedge clk);
        rel_valid = 1'b0;
        chk(rel_err == exp_err, {tag, " rel_err"}, int'(rel_err), int'(exp_err));
        chk(rsp_valid == 1'b0, {tag, " R9 no rsp"}, int'(rsp_valid), 0);
        @(negedge clk);
        chk(rel_err == 1'b0, {tag, " R7 pulse ends"}, int'(rel_err), 0);
    endtask

    task automatic test_reset();
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);
        chk(rel_err == 1'b0, "R1 reset rel_err", int'(rel_err), 0);
        create_op(16'h1000, 3, 1, 0, 0, "R1 first create");
    endtask

    task automatic test_fill_regsets();
        for (int i = 1; i < NREG; i++)
            create_op(16'h1000 + i, i + 3, 1, 0, i, "R2 regset grant");
    endtask

    task automatic test_fallback_frames();
        for (int i = 0; i < NFRM; i++)
            create_op(16'h2000 + i * 7, i + 1, 1, 1, i, "R3 frame fallback");
    endtask

    task automatic test_refuse_and_reuse();
        create_op(16'h3333, 9, 0, 0, 0, "R4 both full");
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 idle no rsp", int'(rsp_valid), 0);
        rd_is_frame = 1'b1; rd_idx = 3'd2; #1;
        chk(int'(rd_addr) == 16'h2000 + 14, "R4 record untouched", int'(rd_addr), 16'h2000 + 14);
        release_op(1, 3, 0, "R6 free frame3");
        create_op(16'h3456, 11, 1, 1, 3, "R6 reuse frame3");
        create_op(16'h3457, 12, 0, 0, 0, "R4 full again");
    endtask

    task automatic test_regset_reuse();
        release_op(0, 2, 0, "R6 free reg2");
        create_op(16'h4002, 5, 1, 0, 2, "R6 reuse reg2");
        release_op(0, 3, 0, "R6 free reg3");
        release_op(0, 1, 0, "R6 free reg1");
        create_op(16'h4001, 6, 1, 0, 1, "R6 lowest reg1");
        create_op(16'h4003, 7, 1, 0, 3, "R6 then reg3");
    endtask

    task automatic test_bad_release();
        release_op(0, 0, 0, "R7 good release reg0");
        release_op(0, 0, 1, "R7 double release reg0");
        release_op(0, 5, 1, "R7 out of range reg5");
        create_op(16'h5000, 8, 1, 0, 0, "R7 only reg0 freed");
        create_op(16'h5001, 8, 0, 0, 0, "R7 no extra entry");
    endtask

    task automatic test_same_cycle();
        create_op(16'h6002, 13, 1, 0, 2, "R8 same-cycle reg2", 1, 0, 2);
        create_op(16'h6004, 14, 1, 1, 4, "R8 same-cycle frame4", 1, 1, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_fill_regsets();
        test_fallback_frames();
        test_refuse_and_reuse();
        test_regset_reuse();
        test_bad_release();
        test_same_cycle();
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 quiet end", int'(rsp_valid), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule